// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a free-running watchdog that guards a system against software that has stopped making progress. A 12-bit down-counter advances once per prescaler period. The prescaler counts pulses on a slow tick input, which stands in for the low-speed oscillator domain. Software must keep writing a refresh key to the control register. If it stops, the counter reaches its end and the block raises a one-clock reset request. The counter then reloads and keeps running.

Configuration is guarded by keys. The divider code and the reload value can only be changed after an unlock key has been written to the control register. Any other key written there locks them again. Each accepted configuration write sets its own busy flag in the status register. That flag stays set until the new value has been carried over into the counting logic, which takes a fixed number of slow ticks. A start key sets the counter running. Nothing but a reset stops it again. The bus accepts 32-bit accesses and 16-bit accesses to the low half-word.

Top module: `key_wdt_top`

## Requirements
- R1: After reset the divider register (word 1) reads 0, the reload register (word 2) reads 0x00000FFF, the status register (word 3) reads 0, and the reset request output is low.
- R2: Writes to the divider and reload registers are ignored unless the most recent control-register write (word 0) carried the key 0x5555 in bits 15:0. Once unlocked, such writes are accepted and read back.
- R3: A control-register write with any key other than 0x5555 locks the configuration registers again, including the refresh key 0xAAAA and any arbitrary value.
- R4: An accepted divider write sets status bit 0, and an accepted reload write sets status bit 1. Each flag is visible from the clock after the write and clears on the third slow tick after the write. The status register is read-only, so writes to it have no effect.
- R5: Until the start key 0xCCCC has been written, the counter does not run and no reset request is produced, however many ticks arrive.
- R6: Once running, with reload value R and divider D, a refresh with 0xAAAA loads the counter and restarts the prescaler. The reset request is then high for exactly one clock, after the edge that samples the R*D-th tick following the refresh.
- R7: The divider code in bits 2:0 selects D as follows: 0→4, 1→8, 2→16, 3→32, 4→64, 5→128, 6→256, 7→256.
- R8: After a reset request the counter reloads from the reload value, and the next request follows R*D ticks later without any refresh.
- R9: A refresh part-way through a period postpones expiry to a full R*D ticks after the refresh.
- R10: Once started, the counter cannot be stopped by any key. Only a reset stops it.
- R11: A write takes effect only when byte enables 1:0 are both set, so 32-bit and low half-word writes work. A write enabling only the upper half-word has no effect, even when it carries a key.
- R12: A new reload value is not used until its busy flag has cleared. A refresh issued while the reload flag is still set loads the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and logic clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bus_valid_i | input | 1 | Access strobe, one cycle per write |
| bus_write_i | input | 1 | High for a write access |
| bus_addr_i | input | 4 | Byte address; bits 3:2 pick control, divider, reload or status |
| bus_be_i | input | 4 | Byte enables of the write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register (combinational) |
| slow_tick_i | input | 1 | One-clock pulse per low-speed clock period |
| wdt_rst_req_o | output | 1 | One-clock reset request on expiry |

## Verification
Register read-back is combinational. Configuration effects are therefore sampled one clock after the write edge. The busy flags are sampled after each of the three ticks that follow a write, so the bench sees the flags still set after two ticks and clear after the third. The reset request is registered on the tick edge that finishes the last period. Every timeout check therefore drives ticks one per clock and samples after each tick edge. The output must be low after the first R*D-1 ticks and high after tick R*D. One idle clock later it must be low again.

// File: rtl/key_wdt_pkg.sv
// Package key_wdt_pkg
// Shared constants for the key-protected watchdog: key codes, field widths,
// register word indices and the divider decode.
// Assumes keys sit in bits 15:0 of a control write.
package key_wdt_pkg;
    localparam int KEY_W     = 16;
    localparam int PSC_W     = 3;
    localparam int CNT_W     = 12;
    localparam int PDIV_W    = 8;
    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

    typedef enum logic [1:0] {
        REG_CTL  = 2'd0,
        REG_PSC  = 2'd1,
        REG_RLD  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    // Returns divider-1 for a code: 4 << code, saturating at 256
    function automatic logic [PDIV_W-1:0] div_m1(input logic [PSC_W-1:0] code);
        logic [PSC_W-1:0] sh;
        logic [PDIV_W:0]  full;
        sh   = (code > 3'd6) ? 3'd6 : code;
        full = (9'd4 << sh) - 9'd1;
        return full[PDIV_W-1:0];
    endfunction
endpackage

// File: rtl/key_wdt_keyreg.sv
// Module key_wdt_keyreg
// Decodes bus writes: control keys (unlock, refresh, start), write-protected
// divider/reload shadow registers, and the combinational read mux.
// Assumes one-cycle write strobes; only byte lanes 1:0 carry meaningful data.
module key_wdt_keyreg #(
    parameter int PSC_W     = 3,
    parameter int CNT_W     = 12,
    parameter int KEY_W     = 16,
    parameter logic [CNT_W-1:0] RLD_RESET = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_valid_i,
    input  logic             bus_write_i,
    input  logic [3:0]       bus_addr_i,
    input  logic [3:0]       bus_be_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    input  logic             psc_busy_i,
    input  logic             rld_busy_i,
    output logic             start_o,
    output logic             refresh_o,
    output logic             psc_load_o,
    output logic             rld_load_o,
    output logic [PSC_W-1:0] psc_shadow_o,
    output logic [CNT_W-1:0] rld_shadow_o
);
    import key_wdt_pkg::*;

    logic             wr_lo;
    logic             ctl_wr;
    logic [KEY_W-1:0] key;
    reg_sel_e         sel;
    logic             unlock_q;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] rld_q;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata_i[31:KEY_W], bus_addr_i[1:0], bus_be_i[3:2]};

    // Decode a write that covers the low half-word
    always_comb begin
        sel        = reg_sel_e'(bus_addr_i[3:2]);
        wr_lo      = bus_valid_i && bus_write_i && (bus_be_i[1:0] == 2'b11);
        key        = bus_wdata_i[KEY_W-1:0];
        ctl_wr     = wr_lo && (sel == REG_CTL);
        start_o    = ctl_wr && (key == KEY_START);
        refresh_o  = ctl_wr && (key == KEY_REFRESH);
        psc_load_o = wr_lo && (sel == REG_PSC) && unlock_q;
        rld_load_o = wr_lo && (sel == REG_RLD) && unlock_q;
    end

    // Lock state follows the last control key written
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     unlock_q <= 1'b0;
        else if (ctl_wr) unlock_q <= (key == KEY_UNLOCK);
    end

    // Shadow registers capture accepted configuration writes
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            psc_q <= '0;
            rld_q <= RLD_RESET;
        end else begin
            if (psc_load_o) psc_q <= bus_wdata_i[PSC_W-1:0];
            if (rld_load_o) rld_q <= bus_wdata_i[CNT_W-1:0];
        end
    end

    // Read mux; control register reads as zero
    always_comb begin
        bus_rdata_o = '0;
        case (sel)
            REG_PSC:  bus_rdata_o[PSC_W-1:0] = psc_q;
            REG_RLD:  bus_rdata_o[CNT_W-1:0] = rld_q;
            REG_STAT: bus_rdata_o[1:0]       = {rld_busy_i, psc_busy_i};
            default:  bus_rdata_o = '0;
        endcase
    end

    assign psc_shadow_o = psc_q;
    assign rld_shadow_o = rld_q;

    assert_locked_psc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_lo && sel == REG_PSC && !unlock_q) |=> $stable(psc_q));
    assert_locked_rld_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_lo && sel == REG_RLD && !unlock_q) |=> $stable(rld_q));
    assert_relock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_wr && key != KEY_UNLOCK) |=> !unlock_q);
    assert_upper_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && bus_write_i && bus_be_i[1:0] == 2'b00)
            |=> ($stable(psc_q) && $stable(rld_q) && $stable(unlock_q)));
endmodule

// File: rtl/key_wdt_sync.sv
// Module key_wdt_sync
// Carries a configuration value into the counting logic. A load sets busy;
// the value becomes active on the SYNC_TICKS-th slow tick after the load.
// Assumes data_i holds steady while busy unless a fresh load restarts it.
module key_wdt_sync #(
    parameter int W          = 12,
    parameter int SYNC_TICKS = 3,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         tick_i,
    output logic         busy_o,
    output logic [W-1:0] active_o
);
    localparam int SC_W = $clog2(SYNC_TICKS + 1);

    logic [SC_W-1:0] cnt_q;

    // Count ticks since the load and transfer the value on the last one
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            busy_o   <= 1'b0;
            cnt_q    <= '0;
            active_o <= RESET_VAL;
        end else if (load_i) begin
            busy_o <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_o && tick_i) begin
            if (cnt_q == SC_W'(SYNC_TICKS - 1)) begin
                busy_o   <= 1'b0;
                active_o <= data_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assert_busy_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> busy_o);
    assert_active_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o != $past(active_o)) |-> ($past(busy_o) && !busy_o));
endmodule

// File: rtl/key_wdt_counter.sv
// Module key_wdt_counter
// Prescaler and down-counter. Runs once started; a refresh reloads the counter
// and restarts the prescaler; the 1->0 step raises a one-clock request and
// reloads. Assumes start and refresh never arrive in the same cycle.
module key_wdt_counter #(
    parameter int PSC_W  = 3,
    parameter int CNT_W  = 12,
    parameter int PDIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             refresh_i,
    input  logic [PSC_W-1:0] div_code_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expire_o
);
    import key_wdt_pkg::*;

    logic              running_q;
    logic [PDIV_W-1:0] pdown_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PDIV_W-1:0] period_m1;

    assign period_m1 = div_m1(div_code_i);

    // Run flag is set by the start key and cleared only by reset
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      running_q <= 1'b0;
        else if (start_i) running_q <= 1'b1;
    end

    // Prescaler, down-counter and expiry pulse
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pdown_q  <= div_m1('0);
            cnt_q    <= '1;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (refresh_i) begin
                cnt_q   <= reload_i;
                pdown_q <= period_m1;
            end else if (start_i && !running_q) begin
                pdown_q <= period_m1;
            end else if (running_q && tick_i) begin
                if (pdown_q == '0) begin
                    pdown_q <= period_m1;
                    if (cnt_q <= CNT_W'(1)) begin
                        cnt_q    <= reload_i;
                        expire_o <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end else begin
                    pdown_q <= pdown_q - 1'b1;
                end
            end
        end
    end

    assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);
    assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !running_q |=> !expire_o);
    assert_run_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running_q |=> running_q);
    assert_refresh_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        refresh_i |=> (cnt_q == $past(reload_i) && !expire_o));
endmodule

// File: rtl/key_wdt_top.sv
// Module key_wdt_top
// Key-protected watchdog: bus key/register decode, two update synchronisers
// (divider and reload) and the prescaled down-counter.
// Assumes slow_tick_i is a one-clock pulse in the clk_i domain.
module key_wdt_top #(
    parameter int SYNC_TICKS = 3
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_valid_i,
    input  logic        bus_write_i,
    input  logic [3:0]  bus_addr_i,
    input  logic [3:0]  bus_be_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    input  logic        slow_tick_i,
    output logic        wdt_rst_req_o
);
    import key_wdt_pkg::*;

    localparam logic [CNT_W-1:0] RLD_RESET = '1;

    logic             start, refresh, psc_load, rld_load;
    logic             psc_busy, rld_busy;
    logic [PSC_W-1:0] psc_shadow, psc_active;
    logic [CNT_W-1:0] rld_shadow, rld_active;

    key_wdt_keyreg #(
        .PSC_W(PSC_W), .CNT_W(CNT_W), .KEY_W(KEY_W), .RLD_RESET(RLD_RESET)
    ) keyreg_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
        .bus_addr_i(bus_addr_i), .bus_be_i(bus_be_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .psc_busy_i(psc_busy), .rld_busy_i(rld_busy),
        .start_o(start), .refresh_o(refresh),
        .psc_load_o(psc_load), .rld_load_o(rld_load),
        .psc_shadow_o(psc_shadow), .rld_shadow_o(rld_shadow)
    );

    key_wdt_sync #(.W(PSC_W), .SYNC_TICKS(SYNC_TICKS), .RESET_VAL('0)) psc_sync_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(psc_load), .data_i(psc_shadow),
        .tick_i(slow_tick_i), .busy_o(psc_busy), .active_o(psc_active)
    );

    key_wdt_sync #(.W(CNT_W), .SYNC_TICKS(SYNC_TICKS), .RESET_VAL(RLD_RESET)) rld_sync_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .load_i(rld_load), .data_i(rld_shadow),
        .tick_i(slow_tick_i), .busy_o(rld_busy), .active_o(rld_active)
    );

    key_wdt_counter #(.PSC_W(PSC_W), .CNT_W(CNT_W), .PDIV_W(PDIV_W)) counter_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(slow_tick_i),
        .start_i(start), .refresh_i(refresh),
        .div_code_i(psc_active), .reload_i(rld_active),
        .expire_o(wdt_rst_req_o)
    );
endmodule

// File: tb/key_wdt_tb.sv
// Bench for key_wdt_top: a vector table of divider/reload/timeout triples,
// then directed tests for locking, status, refresh, restart and reset.
module key_wdt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, wr = 1'b0, tick = 1'b0;
    logic [3:0]  addr = '0, be = '0;
    logic [31:0] wdata = '0, rdata;
    logic        req;
    int          n_tests = 0, n_fail = 0;
    logic        finished = 1'b0;

    localparam logic [3:0] A_CTL = 4'h0, A_PSC = 4'h4, A_RLD = 4'h8, A_STAT = 4'hC;
    localparam int NV = 8;
    localparam int V_CODE [NV] = '{0, 1, 2, 3, 4, 5, 6, 7};
    localparam int V_RLD  [NV] = '{3, 2, 2, 1, 1, 1, 1, 1};
    localparam int V_TICK [NV] = '{12, 16, 32, 32, 64, 128, 256, 256};

    always #10 clk = ~clk;

    key_wdt_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(wr),
        .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .slow_tick_i(tick), .wdt_rst_req_o(req)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr_be(input logic [3:0] a, input logic [31:0] d, input logic [3:0] b);
        @(negedge clk);
        valid = 1'b1; wr = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        valid = 1'b0; wr = 1'b0; be = '0;
    endtask

    task automatic wr32(input logic [3:0] a, input logic [31:0] d);
        wr_be(a, d, 4'hF);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Drives n ticks; request must stay low for n-1 and be high after tick n
    task automatic run_expect(input int n, input string tag);
        int early = 0;
        for (int i = 0; i < n - 1; i++) begin
            tick_once();
            if (req) early++;
        end
        check(early == 0, {tag, " no early request"}, early, 0);
        tick_once();
        check(req == 1'b1, {tag, " request at timeout"}, req, 1);
    endtask

    task automatic configure(input int code, input int rld_v);
        wr32(A_CTL, 32'h5555);
        wr32(A_PSC, code);
        wr32(A_RLD, rld_v);
        repeat (3) tick_once();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_PSC, d);  check(d == 0, "R1 divider reset", d, 0);
        rd(A_RLD, d);  check(d == 32'hFFF, "R1 reload reset", d, 32'hFFF);
        rd(A_STAT, d); check(d == 0, "R1 status reset", d, 0);
        check(req == 0, "R1 request low", req, 0);
        // R2 locked writes ignored
        wr32(A_PSC, 5); wr32(A_RLD, 7);
        rd(A_PSC, d);  check(d == 0, "R2 locked divider", d, 0);
        rd(A_RLD, d);  check(d == 32'hFFF, "R2 locked reload", d, 32'hFFF);
        rd(A_STAT, d); check(d == 0, "R2 no busy when locked", d, 0);
        // R11 upper-half key write has no effect
        wr_be(A_CTL, 32'h5555_0000, 4'b1100); wr32(A_RLD, 9);
        rd(A_RLD, d);  check(d == 32'hFFF, "R11 upper-half unlock ignored", d, 32'hFFF);
        // R3 other keys relock
        wr32(A_CTL, 32'h5555); wr32(A_CTL, 32'h1234); wr32(A_RLD, 9);
        rd(A_RLD, d);  check(d == 32'hFFF, "R3 arbitrary key relocks", d, 32'hFFF);
        wr32(A_CTL, 32'h5555); wr32(A_CTL, 32'hAAAA); wr32(A_RLD, 9);
        rd(A_RLD, d);  check(d == 32'hFFF, "R3 refresh key relocks", d, 32'hFFF);
        // R11 / R2 low half-word access accepted, R4 busy timing
        wr_be(A_CTL, 32'h5555, 4'b0011); wr_be(A_RLD, 32'h2, 4'b0011);
        rd(A_STAT, d); check(d == 2, "R4 reload busy set", d, 2);
        tick_once(); tick_once();
        rd(A_STAT, d); check(d == 2, "R4 busy after two ticks", d, 2);
        tick_once();
        rd(A_STAT, d); check(d == 0, "R4 busy clear on third tick", d, 0);
        rd(A_RLD, d);  check(d == 2, "R2 R11 unlocked half-word write", d, 2);
        wr32(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); check(d == 0, "R4 status read-only", d, 0);
        // R5 no request before start
        wr32(A_CTL, 32'hAAAA);
        begin
            int seen = 0;
            for (int i = 0; i < 40; i++) begin tick_once(); if (req) seen++; end
            check(seen == 0, "R5 idle before start", seen, 0);
        end
        // R6 start and timeout 2*4
        wr32(A_CTL, 32'hCCCC);
        run_expect(8, "R6 first timeout");
        @(negedge clk);
        check(req == 0, "R6 one-clock pulse", req, 0);
        // R7 divider table
        for (int v = 0; v < NV; v++) begin
            configure(V_CODE[v], V_RLD[v]);
            rd(A_PSC, d); check(d == V_CODE[v], "R7 divider readback", d, V_CODE[v]);
            wr32(A_CTL, 32'hAAAA);
            run_expect(V_TICK[v], "R7 divider timeout");
        end
        // R8 automatic reload after expiry
        configure(0, 3);
        wr32(A_CTL, 32'hAAAA);
        run_expect(12, "R8 first period");
        run_expect(12, "R8 reloaded period");
        // R9 refresh mid-way
        repeat (8) tick_once();
        wr32(A_CTL, 32'hAAAA);
        run_expect(12, "R9 refresh postpones");
        // R10 other keys do not stop
        wr32(A_CTL, 32'h0000);
        wr32(A_CTL, 32'h5555);
        run_expect(12, "R10 still running");
        // R12 refresh before sync uses old reload
        wr32(A_CTL, 32'h5555); wr32(A_RLD, 10); wr32(A_CTL, 32'hAAAA);
        run_expect(12, "R12 old reload used");
        run_expect(40, "R12 new reload after sync");
        // R1 reset mid-run
        wr32(A_CTL, 32'h5555); wr32(A_PSC, 3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        rd(A_PSC, d);  check(d == 0, "R1 divider after reset", d, 0);
        rd(A_RLD, d);  check(d == 32'hFFF, "R1 reload after reset", d, 32'hFFF);
        rd(A_STAT, d); check(d == 0, "R1 status after reset", d, 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule